// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This block collects event pulses from three sources that sit outside it: a shift-register transfer, a first timer and a second timer. Each pulse sets a sticky flag bit. Software clears flags by writing ones to them. A separate mask of enable bits decides which flags may raise the interrupt. Only the shift-register and first-timer positions can drive the single interrupt request line.

The block sits on a byte-wide register bus. The register index comes from a 4-bit field of the address. One index selects the flag register and another selects the enable register. Reads are combinational from the address. The enable register has no plain overwrite. Bit 7 of the written byte selects whether the remaining ones are added to the mask or removed from it. Reads of the flag register carry an "anything pending" summary in bit 7.

Top module: `ifu_irq_unit`

## Requirements
- R1: With rst_n low at a clock edge, both registers become zero: flag reads return 0x00, enable reads return 0x80, and irq_req is low.
- R2: A one-cycle pulse on src_shift, src_tmr2 or src_tmr1 sets flag bit 2, 5 or 6 respectively. The bit stays set until software clears it.
- R3: A write to the flag register clears each flag bit written as 1 and leaves each bit written as 0 unchanged.
- R4: A write to the enable register with data bit 7 = 1 ORs data bits 6:0 into the enable mask.
- R5: A write to the enable register with data bit 7 = 0 clears the mask bits whose data bits 6:0 are 1, and keeps the others.
- R6: A flag read returns the flags in bits 6:0. Bit 7 is 1 exactly when some flag is set and also enabled, including the timer-2 position.
- R7: An enable read returns the mask in bits 6:0 with bit 7 always 1.
- R8: irq_req is high exactly when bit 2 or bit 6 is both flagged and enabled. A flagged and enabled bit 5 alone keeps it low.
- R9: The register index is bus_addr[12:9], with 13 for the flag register and 14 for the enable register. Other address bits do not affect decoding. Writes to any other index change neither register, and reads of any other index return 0x00.
- R10: When a source pulse and a software clear hit the same flag bit in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 13 | Register bus address; index in bits 12:9 |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for the current address |
| src_shift | input | 1 | Shift-register event pulse (flag bit 2) |
| src_tmr1 | input | 1 | First-timer event pulse (flag bit 6) |
| src_tmr2 | input | 1 | Second-timer event pulse (flag bit 5) |
| irq_req | output | 1 | Interrupt request |

## Verification
Both registers drive the ports combinationally. A wrong flag or mask bit therefore shows on bus_rdata at the next read of its index, in the cycle after the faulty edge. Through the summary bit and irq_req, the same fault can also show with no read of that register at all. A mask bit wrongly left set shows only when its flag is pending. For this reason, the checks pair every mask change with a pending flag and with flags left unset. Same-cycle set and clear is checked directly at the flag read that follows.

// File: rtl/ifu_pkg.sv
// Package: shared constants for the interrupt flag/enable unit.
// Assumes an 8-bit register bus and fixed source bit positions.
package ifu_pkg;
    localparam int DW        = 8;
    localparam int BIT_SR    = 2;
    localparam int BIT_T2    = 5;
    localparam int BIT_T1    = 6;
    localparam int IDX_W     = 4;
    localparam logic [IDX_W-1:0] IDX_FLAG = 4'd13;
    localparam logic [IDX_W-1:0] IDX_EN   = 4'd14;
    localparam logic [DW-1:0] FLAG_IMPL = (8'h1 << BIT_SR) | (8'h1 << BIT_T2) | (8'h1 << BIT_T1);
    localparam logic [DW-1:0] IRQ_MASK  = (8'h1 << BIT_SR) | (8'h1 << BIT_T1);
endpackage

// File: rtl/ifu_addr_decode.sv
// Module: extracts the register index from the bus address and raises a
// one-hot hit for the flag or enable register. Assumes the index field
// lies wholly inside the address.
module ifu_addr_decode #(
    parameter int ADDR_W  = 13,
    parameter int IDX_LSB = 9
) (
    input  logic [ADDR_W-1:0]          addr,
    output logic [ifu_pkg::IDX_W-1:0]  idx,
    output logic                       hit_flag,
    output logic                       hit_en
);
    import ifu_pkg::*;
    localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

    logic unused_addr;
    assign unused_addr = ^{addr[IDX_LSB-1:0]};

    // Purpose: slice the index and compare against the two register slots.
    always_comb begin
        idx      = addr[IDX_MSB:IDX_LSB];
        hit_flag = (idx == IDX_FLAG);
        hit_en   = (idx == IDX_EN);
    end
endmodule

// File: rtl/ifu_flag_reg.sv
// Module: sticky event flags. A set request beats a clear request on the
// same bit. Only bits in IMPL are stored; the rest read as zero.
module ifu_flag_reg #(
    parameter int                W    = 8,
    parameter logic [W-1:0]      IMPL = 8'h64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_store
            // Purpose: hold one flag; set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)          q[i] <= 1'b0;
                else if (set_vec[i]) q[i] <= 1'b1;
                else if (clr_vec[i]) q[i] <= 1'b0;
            end
        end else begin : g_zero
            logic unused_bit;
            assign unused_bit = set_vec[i] ^ clr_vec[i];
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/ifu_enable_reg.sv
// Module: enable mask with set/clear write semantics chosen by the top
// data bit. Assumes W >= 2; the top bit is a mode bit, not stored.
module ifu_enable_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-2:0] q
);
    // Purpose: OR in or strip out the written ones depending on wdata[W-1].
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr) begin
            if (wdata[W-1]) q <= q | wdata[W-2:0];
            else            q <= q & ~wdata[W-2:0];
        end
    end
endmodule

// File: rtl/ifu_irq_unit.sv
// Module: top of the interrupt flag/enable unit. Decodes the bus, routes
// source pulses to flags, builds read data and the interrupt request.
// Assumes single-cycle writes and side-effect-free reads.
module ifu_irq_unit #(
    parameter int ADDR_W  = 13,
    parameter int IDX_LSB = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              src_shift,
    input  logic              src_tmr1,
    input  logic              src_tmr2,
    output logic              irq_req
);
    import ifu_pkg::*;

    logic [IDX_W-1:0] idx;
    logic             hit_flag, hit_en;
    logic [DW-1:0]    set_vec, clr_vec, flag_q;
    logic [DW-2:0]    en_q;
    logic             pending;

    ifu_addr_decode #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB)) u_dec (
        .addr(bus_addr), .idx(idx), .hit_flag(hit_flag), .hit_en(hit_en)
    );

    // Purpose: map source pulses and software clears onto flag bit vectors.
    always_comb begin
        set_vec         = '0;
        set_vec[BIT_SR] = src_shift;
        set_vec[BIT_T2] = src_tmr2;
        set_vec[BIT_T1] = src_tmr1;
        clr_vec         = (bus_we && hit_flag) ? bus_wdata : '0;
    end

    ifu_flag_reg #(.W(DW), .IMPL(FLAG_IMPL)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .q(flag_q)
    );

    ifu_enable_reg #(.W(DW)) u_en (
        .clk(clk), .rst_n(rst_n), .wr(bus_we && hit_en), .wdata(bus_wdata), .q(en_q)
    );

    // Purpose: summary pending bit and the interrupt line.
    always_comb begin
        pending = |(flag_q[DW-2:0] & en_q);
        irq_req = |(flag_q & {1'b0, en_q} & IRQ_MASK);
    end

    // Purpose: read-data multiplexer over the decoded index.
    always_comb begin
        if (hit_flag)    bus_rdata = {pending, flag_q[DW-2:0]};
        else if (hit_en) bus_rdata = {1'b1, en_q};
        else             bus_rdata = '0;
    end

    logic unused_idx;
    assign unused_idx = ^{idx, flag_q[DW-1]};
endmodule

// File: rtl/ifu_irq_unit_chk.sv
// Module: property checker for ifu_irq_unit, attached by bind below.
// Observes bus inputs and the two register outputs from their submodules.
module ifu_irq_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [12:0] bus_addr,
    input logic        bus_we,
    input logic [7:0]  bus_wdata,
    input logic        src_shift,
    input logic        src_tmr1,
    input logic        src_tmr2,
    input logic [7:0]  flag_q,
    input logic [6:0]  en_q
);
    logic wr_flag, wr_en;
    assign wr_flag = bus_we && (bus_addr[12:9] == 4'd13);
    assign wr_en   = bus_we && (bus_addr[12:9] == 4'd14);

    // R1: first cycle out of reset sees cleared registers
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flag_q == 8'h00 && en_q == 7'h00));

    // R2: a shift pulse leaves flag bit 2 set
    p_src_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        src_shift |=> flag_q[2]);

    // R3: clearing timer-2 flag with no pulse leaves it clear
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && bus_wdata[5] && !src_tmr2) |=> !flag_q[5]);

    // R4: set-mode write adds the written ones
    p_en_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_wdata[7]) |=> ((en_q & $past(bus_wdata[6:0])) == $past(bus_wdata[6:0])));

    // R5: clear-mode write removes the written ones
    p_en_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bus_wdata[7]) |=> ((en_q & $past(bus_wdata[6:0])) == 7'h00));

    // R10: set beats a same-cycle clear on timer-1
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (src_tmr1 && wr_flag && bus_wdata[6]) |=> flag_q[6]);
endmodule

bind ifu_irq_unit ifu_irq_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .src_shift(src_shift), .src_tmr1(src_tmr1),
    .src_tmr2(src_tmr2), .flag_q(flag_q), .en_q(en_q)
);

// File: tb/ifu_irq_unit_bench.sv
module ifu_irq_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        src_shift = 1'b0, src_tmr1 = 1'b0, src_tmr2 = 1'b0;
    logic        irq_req;
    int          n_checks = 0;
    int          n_fail = 0;
    int          cycles = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    ifu_irq_unit u_ifu_irq_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_shift(src_shift),
        .src_tmr1(src_tmr1), .src_tmr2(src_tmr2), .irq_req(irq_req)
    );

    // Vector: kind[29:28] (0 write, 1 read-check, 2 source pulse), idx[27:24],
    // data[23:16], src {t2,t1,sr}[15:13], exp rdata[12:5], exp irq[4], req[3:0]
    localparam int NV = 27;
    localparam logic [29:0] VEC [NV] = '{
        {2'd1, 4'd13, 8'h00, 3'b000, 8'h00, 1'b0, 4'd1},  // R1 flags zero
        {2'd1, 4'd14, 8'h00, 3'b000, 8'h80, 1'b0, 4'd7},  // R7 enable reads 0x80
        {2'd0, 4'd14, 8'h84, 3'b000, 8'h00, 1'b0, 4'd4},
        {2'd1, 4'd14, 8'h00, 3'b000, 8'h84, 1'b0, 4'd4},  // R4 bit 2 enabled
        {2'd2, 4'd0,  8'h00, 3'b001, 8'h00, 1'b0, 4'd2},
        {2'd1, 4'd13, 8'h00, 3'b000, 8'h84, 1'b1, 4'd2},  // R2 R6 R8 shift flag
        {2'd2, 4'd0,  8'h00, 3'b100, 8'h00, 1'b0, 4'd2},
        {2'd1, 4'd13, 8'h00, 3'b000, 8'hA4, 1'b1, 4'd2},  // R2 timer2 flag
        {2'd0, 4'd13, 8'h04, 3'b000, 8'h00, 1'b0, 4'd3},
        {2'd1, 4'd13, 8'h00, 3'b000, 8'h20, 1'b0, 4'd3},  // R3 only bit2 cleared; R6 no summary
        {2'd0, 4'd14, 8'hA0, 3'b000, 8'h00, 1'b0, 4'd4},
        {2'd1, 4'd13, 8'h00, 3'b000, 8'hA0, 1'b0, 4'd8},  // R8 timer2 alone no irq; R6 summary
        {2'd0, 4'd14, 8'h04, 3'b000, 8'h00, 1'b0, 4'd5},
        {2'd1, 4'd14, 8'h00, 3'b000, 8'hA0, 1'b0, 4'd5},  // R5 bit2 removed, bit5 kept
        {2'd2, 4'd0,  8'h00, 3'b010, 8'h00, 1'b0, 4'd2},
        {2'd1, 4'd13, 8'h00, 3'b000, 8'hE0, 1'b0, 4'd8},  // R8 timer1 not enabled
        {2'd0, 4'd14, 8'hC0, 3'b000, 8'h00, 1'b0, 4'd4},
        {2'd1, 4'd13, 8'h00, 3'b000, 8'hE0, 1'b1, 4'd8},  // R8 timer1 raises irq
        {2'd0, 4'd14, 8'h00, 3'b000, 8'h00, 1'b0, 4'd5},
        {2'd1, 4'd14, 8'h00, 3'b000, 8'hE0, 1'b1, 4'd5},  // R5 zero data keeps mask
        {2'd0, 4'd12, 8'hFF, 3'b000, 8'h00, 1'b0, 4'd9},
        {2'd0, 4'd15, 8'h7F, 3'b000, 8'h00, 1'b0, 4'd9},
        {2'd1, 4'd13, 8'h00, 3'b000, 8'hE0, 1'b1, 4'd9},  // R9 other index ignored
        {2'd1, 4'd14, 8'h00, 3'b000, 8'hE0, 1'b1, 4'd9},  // R9 mask untouched
        {2'd1, 4'd12, 8'h00, 3'b000, 8'h00, 1'b1, 4'd9},  // R9 unmapped reads zero
        {2'd0, 4'd13, 8'hFF, 3'b000, 8'h00, 1'b0, 4'd3},
        {2'd1, 4'd13, 8'h00, 3'b000, 8'h00, 1'b0, 4'd3}   // R3 all flags cleared
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic do_write(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_pulse(input logic [2:0] s);
        @(negedge clk);
        {src_tmr2, src_tmr1, src_shift} = s;
        @(negedge clk);
        {src_tmr2, src_tmr1, src_shift} = 3'b000;
    endtask

    task automatic do_read(input logic [12:0] a, input logic [7:0] exp_d,
                           input logic exp_i, input string tag);
        @(negedge clk);
        bus_addr = a;
        #2;
        check({tag, " rdata"}, bus_rdata, exp_d);
        check({tag, " irq"}, {7'b0, irq_req}, {7'b0, exp_i});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int v = 0; v < NV; v++) begin
            logic [29:0] e;
            e = VEC[v];
            case (e[29:28])
                2'd0: do_write({e[27:24], 9'h000}, e[23:16]);
                2'd1: do_read({e[27:24], 9'h000}, e[12:5], e[4], $sformatf("R%0d vec%0d", e[3:0], v));
                default: do_pulse(e[15:13]);
            endcase
        end

        // R10: timer-1 pulse and software clear of bit 6 in the same cycle
        @(negedge clk);
        bus_addr = {4'd13, 9'h000}; bus_wdata = 8'h40; bus_we = 1'b1; src_tmr1 = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; src_tmr1 = 1'b0;
        do_read({4'd13, 9'h000}, 8'hC0, 1'b1, "R10 set wins");

        // R9: low address bits ignored; clear-mode write of 0x7F via offset address
        do_write({4'd14, 9'h1FF}, 8'h7F);
        do_read({4'd14, 9'h0A5}, 8'h80, 1'b0, "R9 low bits ignored");

        // R1: reset mid-run clears pending flags and mask
        do_write({4'd14, 9'h000}, 8'hFF);
        do_pulse(3'b111);
        do_read({4'd13, 9'h000}, 8'hE4, 1'b1, "R2 all sources");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        do_read({4'd13, 9'h000}, 8'h00, 1'b0, "R1 flags after reset");
        do_read({4'd14, 9'h000}, 8'h80, 1'b0, "R1 mask after reset");

        done = 1'b1;
        report();
    end
endmodule